// File: doc/BRIEF.md
# Lane-Wise Toggle-Limiting Bus Inversion Encoder

This block drives a wide active-low data bus that moves several beats per bus clock. The bus is cut into 16-bit lanes, and every lane of every beat gets an inversion flag and a parity bit of its own. For each beat and lane, the encoder counts how many wires would change level against the level that lane last drove. When more than half would change, it drives the lane's true data instead of its complement and asserts the lane's flag. The decisions chain from beat to beat inside one clock and carry over from the last beat of one clock to the first beat of the next.

Alongside the data the block drives a ready strobe for each clock that carries beats, and a busy indication that spans a whole burst, idle gaps included. When no beats are offered, the lanes repeat their last driven level, so an idle clock toggles nothing. A receive path in the same module takes bus wires, flags and ready, removes the inversion and presents the recovered data. A loopback of the two paths gives the original words back.

Top module: `lane_flip_encoder`

## Requirements
- R1: Bus beat b occupies bits [b*64 +: 64] of `bus_d_n`, with beat 0 first on the wire. Lane k of beat b is bits [b*64+k*16 +: 16]. Its inversion flag is `bus_inv_n[b*4+k]` and its parity bit is `bus_par_n[b*4+k]`.
- R2: A lane is inverted only when strictly more than 8 of its 16 wires would toggle if it were driven plainly. Exactly 8 toggles leaves it plain.
- R3: The toggle count compares against the wire levels actually driven on the previous beat, after inversion. That previous beat is the prior beat of the same clock, or beat 3 of the last clock that drove the bus. After reset the reference is all wires high.
- R4: A plain lane drives the complement of its data (active low) with flag high. An inverted lane drives the data unchanged with flag low.
- R5: Each parity bit is the complement of the XOR of the 16 wire levels of its lane as driven.
- R6: Beats offered with `src_vld` high at a rising edge appear on the bus after that edge, with `bus_rdy_n` low for that one clock. `bus_rdy_n` is high after any edge where `src_vld` was low.
- R7: On an idle clock every beat repeats the last driven beat's wires, flags and parity.
- R8: `bus_busy_n` is low from the first ready clock of a burst until the clock that carries the beat group marked `src_last`, including idle gaps. It goes high the clock after that group unless a new group follows.
- R9: The receive path outputs `rx_data` = ~`rx_d_n` per lane, XORed with all ones where that lane's `rx_inv_n` is low. `rx_vld` is the complement of `rx_rdy_n`.
- R10: No lane ever toggles more than 8 wires between two consecutive driven beats, across clock boundaries included.
- R11: During reset all bus outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_vld | input | 1 | A group of beats is offered this clock |
| src_last | input | 1 | The offered group ends the burst |
| src_data | input | 256 | Logical data of the offered beats, beat 0 in the low bits |
| bus_d_n | output | 256 | Driven wire levels of the beats |
| bus_inv_n | output | 16 | Inversion flags, one per beat and lane, low = inverted |
| bus_par_n | output | 16 | Lane parity bits, one per beat and lane |
| bus_rdy_n | output | 1 | Low while the bus carries valid beats |
| bus_busy_n | output | 1 | Low while the burst owns the bus |
| rx_d_n | input | 256 | Received wire levels |
| rx_inv_n | input | 16 | Received inversion flags |
| rx_rdy_n | input | 1 | Received ready |
| rx_data | output | 256 | Recovered logical data |
| rx_vld | output | 1 | Recovered data is valid |

## Verification
Two things meet in one clock: an inversion choice for the first beat of a group, and the hold left on the wires by an idle clock just before. That first choice must count toggles against the held level and not against stale data. The bench provokes this by putting gaps of random length inside bursts and by following them with words built to sit near the 8-toggle threshold. A model that keeps only the last driven level judges each result. The same clocks also test busy: it must stay low across a gap and go high only after the group marked last.

// File: rtl/lane_flip_encoder.sv
module lane_flip_encoder #(
  parameter int BEATS  = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            src_vld,
  input  logic                            src_last,
  input  logic [BEATS*LANES*LANE_W-1:0]   src_data,
  output logic [BEATS*LANES*LANE_W-1:0]   bus_d_n,
  output logic [BEATS*LANES-1:0]          bus_inv_n,
  output logic [BEATS*LANES-1:0]          bus_par_n,
  output logic                            bus_rdy_n,
  output logic                            bus_busy_n,
  input  logic [BEATS*LANES*LANE_W-1:0]   rx_d_n,
  input  logic [BEATS*LANES-1:0]          rx_inv_n,
  input  logic                            rx_rdy_n,
  output logic [BEATS*LANES*LANE_W-1:0]   rx_data,
  output logic                            rx_vld
);
  localparam int BUS_W = LANES * LANE_W;
  localparam int ALL_W = BEATS * BUS_W;
  localparam int FLAGS = BEATS * LANES;
  localparam int LIMIT = LANE_W / 2;
  localparam logic IDLE_PAR = ~(^{LANE_W{1'b1}});

  logic [ALL_W-1:0] d_q, d_nxt;
  logic [FLAGS-1:0] inv_q, inv_nxt, par_q, par_nxt;
  logic             rdy_q, busy_q;
  logic [BUS_W-1:0] last_w;

  assign last_w = d_q[ALL_W-1 -: BUS_W];

  always_comb begin
    logic [BUS_W-1:0]  ref_w;
    logic [LANE_W-1:0] cand, w;
    logic              flip;
    ref_w   = last_w;
    d_nxt   = '0;
    inv_nxt = '1;
    par_nxt = '1;
    for (int b = 0; b < BEATS; b++) begin
      for (int k = 0; k < LANES; k++) begin
        cand = ~src_data[b*BUS_W + k*LANE_W +: LANE_W];
        flip = $countones(cand ^ ref_w[k*LANE_W +: LANE_W]) > LIMIT;
        w    = flip ? ~cand : cand;
        d_nxt[b*BUS_W + k*LANE_W +: LANE_W] = w;
        inv_nxt[b*LANES + k] = ~flip;
        par_nxt[b*LANES + k] = ~(^w);
        ref_w[k*LANE_W +: LANE_W] = w;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q    <= '1;
      inv_q  <= '1;
      par_q  <= {FLAGS{IDLE_PAR}};
      rdy_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (src_vld) begin
      d_q    <= d_nxt;
      inv_q  <= inv_nxt;
      par_q  <= par_nxt;
      rdy_q  <= 1'b1;
      busy_q <= ~src_last;
    end else begin
      d_q    <= {BEATS{last_w}};
      inv_q  <= {BEATS{inv_q[FLAGS-1 -: LANES]}};
      par_q  <= {BEATS{par_q[FLAGS-1 -: LANES]}};
      rdy_q  <= 1'b0;
    end
  end

  assign bus_d_n    = d_q;
  assign bus_inv_n  = inv_q;
  assign bus_par_n  = par_q;
  assign bus_rdy_n  = ~rdy_q;
  assign bus_busy_n = ~(rdy_q | busy_q);

  for (genvar g = 0; g < FLAGS; g++) begin : g_rx
    assign rx_data[g*LANE_W +: LANE_W] =
      ~rx_d_n[g*LANE_W +: LANE_W] ^ {LANE_W{~rx_inv_n[g]}};
  end
  assign rx_vld = ~rx_rdy_n;
endmodule

module lane_flip_encoder_chk #(
  parameter int BEATS  = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          src_vld,
  input logic [BEATS*LANES*LANE_W-1:0] bus_d_n,
  input logic [BEATS*LANES-1:0]        bus_inv_n,
  input logic [BEATS*LANES-1:0]        bus_par_n,
  input logic                          bus_rdy_n,
  input logic                          bus_busy_n
);
  localparam int BUS_W = LANES * LANE_W;
  localparam int ALL_W = BEATS * BUS_W;

  a_r8_busy_covers_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdy_n |-> !bus_busy_n);

  a_r8_release_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy_n) |-> $past(!bus_rdy_n));

  a_r6_ready_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    src_vld |=> !bus_rdy_n);

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy_n |-> bus_d_n[BUS_W-1:0] == $past(bus_d_n[ALL_W-1 -: BUS_W]));

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int LO = b*BUS_W + k*LANE_W;
      a_r5_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (^{bus_d_n[LO +: LANE_W], ~bus_par_n[b*LANES+k]}) == 1'b0);
      if (b > 0) begin : g_in
        a_r10_toggle_limit: assert property (@(posedge clk) disable iff (!rst_n)
          $countones(bus_d_n[LO +: LANE_W] ^ bus_d_n[LO-BUS_W +: LANE_W]) <= LANE_W/2);
      end else begin : g_cross
        a_r10_toggle_limit_edge: assert property (@(posedge clk) disable iff (!rst_n)
          $countones(bus_d_n[LO +: LANE_W] ^ $past(bus_d_n[ALL_W-BUS_W+k*LANE_W +: LANE_W]))
            <= LANE_W/2);
      end
    end
  end
endmodule

bind lane_flip_encoder lane_flip_encoder_chk #(
  .BEATS(BEATS), .LANES(LANES), .LANE_W(LANE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .bus_d_n(bus_d_n),
  .bus_inv_n(bus_inv_n), .bus_par_n(bus_par_n),
  .bus_rdy_n(bus_rdy_n), .bus_busy_n(bus_busy_n)
);

// File: tb/lane_flip_encoder_bench.sv
module lane_flip_encoder_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         src_vld = 1'b0, src_last = 1'b0;
  logic [255:0] src_data = '0;
  logic [255:0] bus_d_n, rx_data;
  logic [15:0]  bus_inv_n, bus_par_n;
  logic         bus_rdy_n, bus_busy_n, rx_vld;

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [63:0]  m_last = '1;
  logic [255:0] e_d = '1, sent = '0;
  logic [15:0]  e_inv = '1, e_par = '1;
  logic         e_rdy_n = 1'b1, e_busy_n = 1'b1, m_busy = 1'b0;
  logic [63:0]  seen_last = '1;

  always #2 clk = ~clk;

  lane_flip_encoder u_lane_flip_encoder (
    .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .src_last(src_last),
    .src_data(src_data), .bus_d_n(bus_d_n), .bus_inv_n(bus_inv_n),
    .bus_par_n(bus_par_n), .bus_rdy_n(bus_rdy_n), .bus_busy_n(bus_busy_n),
    .rx_d_n(bus_d_n), .rx_inv_n(bus_inv_n), .rx_rdy_n(bus_rdy_n),
    .rx_data(rx_data), .rx_vld(rx_vld)
  );

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // Reference: plain drive is the complement, flip when strictly more than 8 toggle.
  task automatic model(logic v, logic l, logic [255:0] d);
    if (v) begin
      for (int b = 0; b < 4; b++)
        for (int k = 0; k < 4; k++) begin
          logic [15:0] lane, w;
          int t;
          lane = d[b*64 + k*16 +: 16];
          t = $countones(~lane ^ m_last[k*16 +: 16]);
          w = (t > 8) ? lane : ~lane;
          e_d[b*64 + k*16 +: 16] = w;
          e_inv[b*4 + k] = !(t > 8);
          e_par[b*4 + k] = ~(^w);
          m_last[k*16 +: 16] = w;
        end
      m_busy = !l;
    end else begin
      e_d   = {4{m_last}};
      e_inv = {4{e_inv[15:12]}};
      e_par = {4{e_par[15:12]}};
    end
    e_rdy_n  = !v;
    e_busy_n = !(v || m_busy);
  endtask

  task automatic cycle(logic v, logic l, logic [255:0] d);
    @(negedge clk);
    src_vld = v; src_last = l; src_data = d;
    model(v, l, d);
    @(posedge clk);
    #1;
    chk("R1 R3 R4 wires", bus_d_n, e_d);
    chk("R2 flags", {240'd0, bus_inv_n}, {240'd0, e_inv});
    chk("R5 parity", {240'd0, bus_par_n}, {240'd0, e_par});
    chk("R6 ready", {255'd0, bus_rdy_n}, {255'd0, e_rdy_n});
    chk("R8 busy", {255'd0, bus_busy_n}, {255'd0, e_busy_n});
    chk("R9 rx_vld", {255'd0, rx_vld}, {255'd0, !e_rdy_n});
    if (!bus_rdy_n) chk("R9 round trip", rx_data, d);
    if (bus_rdy_n) chk("R7 idle hold", bus_d_n, {4{seen_last}});
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 4; k++) begin
        logic [15:0] pv;
        int t;
        pv = (b == 0) ? seen_last[k*16 +: 16] : bus_d_n[(b-1)*64 + k*16 +: 16];
        t = $countones(pv ^ bus_d_n[b*64 + k*16 +: 16]);
        if (t > 8) begin
          compared++; mismatched++;
          $display("FAIL R10 toggles act=%0d exp=<=8 beat=%0d lane=%0d", t, b, k);
        end
      end
    seen_last = bus_d_n[255:192];
  endtask

  initial begin
    #800000;
    compared++; mismatched++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end

  initial begin
    logic [255:0] d;
    repeat (3) @(negedge clk);
    chk("R11 reset wires", bus_d_n, '1);
    chk("R11 reset flags/parity", {224'd0, bus_inv_n, bus_par_n}, {224'd0, 32'hFFFF_FFFF});
    chk("R11 reset ready/busy", {254'd0, bus_rdy_n, bus_busy_n}, {254'd0, 2'b11});
    rst_n = 1'b1;
    cycle(0, 0, '0);
    // R2 threshold from reset reference: 8 ones plain, 9 ones inverted, 0 plain, 16 inverted
    d = '0;
    d[63:0] = {16'hFFFF, 16'h0000, 16'h01FF, 16'h00FF};
    cycle(1, 0, d);
    chk("R2 exactly 8 plain / 9 inverted", {252'd0, bus_inv_n[3:0]}, {252'd0, 4'b0101});
    // R3: same word again, compared against inverted levels
    cycle(1, 0, {4{64'hFFFF_0000_01FF_00FF}});
    cycle(0, 0, '0);
    cycle(0, 0, '0);
    cycle(1, 1, {4{64'h0000_FFFF_FE00_FF00}});
    cycle(0, 0, '0);
    cycle(1, 0, {4{64'h5555_AAAA_0F0F_F0F0}});
    cycle(1, 1, {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0});
    for (int n = 0; n < 400; n++) begin
      logic [255:0] r;
      logic v;
      for (int w = 0; w < 8; w++) r[w*32 +: 32] = $urandom;
      if (n % 3 == 0)
        for (int g = 0; g < 16; g++)
          r[g*16 +: 16] = ($urandom % 2) ? 16'h00FF ^ r[g*16 +: 16] & 16'h0101 : r[g*16 +: 16];
      v = ($urandom % 4) != 0;
      cycle(v, v && (($urandom % 5) == 0), r);
    end
    cycle(0, 0, '0);
    cycle(0, 0, '0);
    summary();
  end
endmodule